// File: doc/BRIEF.md
# Digit-Serial Multiword Decimal/Binary Adder

This block adds or subtracts two signed operands of one to four 24-bit words. One 4-bit digit adder is reused for every digit. The adder works bit-parallel inside a digit and serially across digits, least significant digit first, at one digit per clock. A run-time mode bit picks decimal (BCD) or binary digit arithmetic.

The caller presents both operands on 96-bit buses with their sign bits, the mode, an add/subtract select, the word count and the bounds of a digit field, then pulses `start`. Only digits inside the field are computed. Every other digit of the result is a copy of operand A. The result, its sign and an overflow flag stay valid until the next start, and `done` pulses once for each operation.

Subtraction complements the subtrahend digit by digit: nines' complement in decimal mode, ones' complement in binary mode, with an initial carry of one. When the magnitude comes out negative, a second serial pass recomplements it and the sign is flipped.

Top module: `digit_serial_adder`

## Requirements
- R1: While `rst` is high, and after it, until the first start: `busy`, `done`, `ovf` and `sum_neg` are 0 and `sum_val` is all zeros.
- R2: In binary mode (`dec_mode`=0), each field digit is the 4-bit sum of the operand digits and the incoming carry. The carry out of bit 3 feeds the next higher digit.
- R3: In decimal mode (`dec_mode`=1), a digit sum above 9 is corrected by adding 6 and produces a carry, so every field digit of the result is a BCD digit 0..9.
- R4: When the effective operation is a subtraction and |A| >= |B| over the field, `sum_val` holds |A|-|B| and `sum_neg` equals `a_neg`. Equal magnitudes give zero with `sum_neg` = `a_neg`.
- R5: When the effective operation is a subtraction and |A| < |B|, the result is recomplemented in a second pass. `sum_val` then holds |B|-|A| and `sum_neg` is the inverse of `a_neg`.
- R6: Digits of `sum_val` outside the field equal the corresponding digits of `a_val` at start. They are never written during a run.
- R7: Carry does not cross the field: the digit above `fld_hi` is unchanged, and the digit index stays inside the field while busy.
- R8: `ovf` is 1 only when an effective addition carries out of the top field digit. It is always 0 after an effective subtraction.
- R9: Sign-magnitude rule: the effective operation is a subtraction when `sub_op` XOR `a_neg` XOR `b_neg` is 1, and an addition otherwise. For an addition, `sum_neg` equals `a_neg`.
- R10: `word_cnt` value k selects k+1 words. The field's top digit is clamped to 6(k+1)-1, and the bottom digit is clamped to no more than the top.
- R11: `done` is a one-cycle pulse seen n+1 clocks after the start edge cycle for a field of n digits, or 2n+1 when recomplemented. `busy` is high from the start edge until `done`, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dec_mode | input | 1 | 1 = decimal digits, 0 = binary digits |
| sub_op | input | 1 | 1 = subtract B from A, 0 = add |
| word_cnt | input | 2 | Operand length minus one, in words |
| fld_lo | input | 5 | Lowest digit index of the field |
| fld_hi | input | 5 | Highest digit index of the field |
| a_val | input | 96 | Operand A, digit 0 in bits 3:0 |
| a_neg | input | 1 | Sign of A (1 = negative) |
| b_val | input | 96 | Operand B |
| b_neg | input | 1 | Sign of B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sum_val | output | 96 | Result |
| sum_neg | output | 1 | Result sign |
| ovf | output | 1 | Addition overflow out of the field |

## Verification
Several rules are checked by assertions on every clock:
- `done` lasts one cycle and never coincides with `busy`.
- The digit pointer stays inside the clamped field.
- Digits outside the field never change during a run.
- A decimal digit sum of two BCD digits is itself BCD.
- Overflow is never reported for an effective subtraction.

Only the bench scenarios can show the arithmetic values and signs after the recomplement pass, the clamping by word count, the latency counts, and that a start while busy is ignored. For these it compares against an independent compare-then-subtract model over both modes, all four lengths and random field bounds.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    localparam int DIGIT_W      = 4;
    localparam int WORD_W       = 24;
    localparam int MAX_WORDS    = 4;
    localparam int DIG_PER_WORD = WORD_W / DIGIT_W;
    localparam int MAX_DIGITS   = MAX_WORDS * DIG_PER_WORD;
    localparam int OPND_W       = MAX_WORDS * WORD_W;
    localparam int IDX_W        = $clog2(MAX_DIGITS);
    localparam int WCNT_W       = $clog2(MAX_WORDS);

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADD,
        PH_RECOMP
    } phase_e;

    typedef struct packed {
        logic dec;
        logic eff_sub;
        logic neg;
    } op_ctl_t;

    // radix-minus-one complement of a digit
    function automatic digit_t digit_comp(digit_t d, logic dec);
        return dec ? digit_t'(digit_t'(9) - d) : ~d;
    endfunction

    // highest digit index reachable with (wc+1) words
    function automatic idx_t field_top(logic [WCNT_W-1:0] wc);
        return idx_t'((int'(wc) + 1) * DIG_PER_WORD - 1);
    endfunction
endpackage

// File: rtl/dsa_digit_adder.sv
module dsa_digit_adder
    import dsa_pkg::*;
(
    input  digit_t a_i,
    input  digit_t b_i,
    input  logic   cin_i,
    input  logic   dec_i,
    output digit_t sum_o,
    output logic   cout_o
);
    logic [DIGIT_W:0] raw;
    logic [DIGIT_W:0] fixed;

    always_comb begin
        raw = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
        if (dec_i && raw > (DIGIT_W+1)'(9)) begin
            fixed  = raw + (DIGIT_W+1)'(6);
            cout_o = 1'b1;
        end else begin
            fixed  = raw;
            cout_o = dec_i ? 1'b0 : raw[DIGIT_W];
        end
        sum_o = fixed[DIGIT_W-1:0];
    end

    // R3: two BCD digits always produce a BCD digit
    always_comb begin
        if (dec_i && a_i <= digit_t'(9) && b_i <= digit_t'(9)) begin
            assert_bcd_digit_R3: assert (sum_o <= digit_t'(9))
                else $error("decimal digit sum out of range");
        end
    end
endmodule

// File: rtl/dsa_field_seq.sv
module dsa_field_seq
    import dsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  idx_t lo_i,
    input  idx_t hi_i,
    input  logic restart_i,
    input  logic step_i,
    input  logic active_i,
    output idx_t idx_o,
    output logic last_o,
    output idx_t lo_o,
    output idx_t hi_o
);
    idx_t idx_q, lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (load_i) begin
            idx_q <= lo_i;
            lo_q  <= lo_i;
            hi_q  <= hi_i;
        end else if (restart_i) begin
            idx_q <= lo_q;
        end else if (step_i) begin
            idx_q <= idx_q + idx_t'(1);
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == hi_q);
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;

    // R7: the digit pointer never leaves the field while running
    assert_idx_in_field_R7: assert property (@(posedge clk) disable iff (rst)
        active_i |-> (idx_q >= lo_q && idx_q <= hi_q))
        else $error("digit index outside field");
endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder
    import dsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dec_mode,
    input  logic              sub_op,
    input  logic [WCNT_W-1:0] word_cnt,
    input  logic [IDX_W-1:0]  fld_lo,
    input  logic [IDX_W-1:0]  fld_hi,
    input  logic [OPND_W-1:0] a_val,
    input  logic              a_neg,
    input  logic [OPND_W-1:0] b_val,
    input  logic              b_neg,
    output logic              busy,
    output logic              done,
    output logic [OPND_W-1:0] sum_val,
    output logic              sum_neg,
    output logic              ovf
);
    phase_e            phase_q;
    op_ctl_t           ctl_q;
    logic [OPND_W-1:0] a_q, b_q, res_q;
    logic              carry_q, done_q, ovf_q;

    idx_t idx, lo_q, hi_q, hi_eff, lo_eff;
    logic last, load, need_recomp, restart, step, running;

    // clamp the field to the operand length
    always_comb begin
        hi_eff = field_top(word_cnt);
        if (fld_hi < hi_eff) hi_eff = fld_hi;
        lo_eff = (fld_lo > hi_eff) ? hi_eff : fld_lo;
    end

    digit_t a_dig, b_dig, r_dig, da, db, sum_d;
    logic   carry_out;

    assign a_dig = a_q[idx*DIGIT_W +: DIGIT_W];
    assign b_dig = b_q[idx*DIGIT_W +: DIGIT_W];
    assign r_dig = res_q[idx*DIGIT_W +: DIGIT_W];

    always_comb begin
        if (phase_q == PH_RECOMP) begin
            da = digit_comp(r_dig, ctl_q.dec);
            db = '0;
        end else begin
            da = a_dig;
            db = ctl_q.eff_sub ? digit_comp(b_dig, ctl_q.dec) : b_dig;
        end
    end

    dsa_digit_adder u_adder (
        .a_i    (da),
        .b_i    (db),
        .cin_i  (carry_q),
        .dec_i  (ctl_q.dec),
        .sum_o  (sum_d),
        .cout_o (carry_out)
    );

    assign running     = (phase_q != PH_IDLE);
    assign load        = (phase_q == PH_IDLE) && start;
    assign need_recomp = (phase_q == PH_ADD) && last && ctl_q.eff_sub && !carry_out;
    assign restart     = need_recomp;
    assign step        = running && !last;

    dsa_field_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .lo_i      (lo_eff),
        .hi_i      (hi_eff),
        .restart_i (restart),
        .step_i    (step),
        .active_i  (running),
        .idx_o     (idx),
        .last_o    (last),
        .lo_o      (lo_q),
        .hi_o      (hi_q)
    );

    // per-digit field mask, used by the checks below
    logic [OPND_W-1:0] field_mask;
    for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_mask
        assign field_mask[g*DIGIT_W +: DIGIT_W] =
            {DIGIT_W{(idx_t'(g) >= lo_q) && (idx_t'(g) <= hi_q)}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ctl_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            res_q   <= '0;
            carry_q <= 1'b0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        a_q           <= a_val;
                        b_q           <= b_val;
                        res_q         <= a_val;
                        ctl_q.dec     <= dec_mode;
                        ctl_q.eff_sub <= sub_op ^ a_neg ^ b_neg;
                        ctl_q.neg     <= a_neg;
                        carry_q       <= sub_op ^ a_neg ^ b_neg;
                        ovf_q         <= 1'b0;
                        phase_q       <= PH_ADD;
                    end
                end
                PH_ADD: begin
                    res_q[idx*DIGIT_W +: DIGIT_W] <= sum_d;
                    carry_q <= carry_out;
                    if (need_recomp) begin
                        carry_q <= 1'b1;
                        phase_q <= PH_RECOMP;
                    end else if (last) begin
                        ovf_q   <= !ctl_q.eff_sub && carry_out;
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                PH_RECOMP: begin
                    res_q[idx*DIGIT_W +: DIGIT_W] <= sum_d;
                    carry_q <= carry_out;
                    if (last) begin
                        ctl_q.neg <= ~ctl_q.neg;
                        done_q    <= 1'b1;
                        phase_q   <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy    = running;
    assign done    = done_q;
    assign sum_val = res_q;
    assign sum_neg = ctl_q.neg;
    assign ovf     = ovf_q;

    // R11: completion strobe lasts one cycle and never overlaps busy
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle");
    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy");
    // R8: overflow only after an effective addition
    assert_ovf_add_only_R8: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> !ctl_q.eff_sub) else $error("overflow on subtraction");
    // R6: digits outside the field are never written during a run
    assert_outside_stable_R6: assert property (@(posedge clk) disable iff (rst)
        running |=> (((res_q ^ $past(res_q)) & ~field_mask) == '0))
        else $error("digit outside field changed");
endmodule

// File: tb/digit_serial_adder_tb.sv
module digit_serial_adder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, dec_mode, sub_op, a_neg, b_neg;
    logic [1:0]  word_cnt;
    logic [4:0]  fld_lo, fld_hi;
    logic [95:0] a_val, b_val;
    logic        busy, done, sum_neg, ovf;
    logic [95:0] sum_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    digit_serial_adder u_dut (
        .clk(clk), .rst(rst), .start(start), .dec_mode(dec_mode), .sub_op(sub_op),
        .word_cnt(word_cnt), .fld_lo(fld_lo), .fld_hi(fld_hi),
        .a_val(a_val), .a_neg(a_neg), .b_val(b_val), .b_neg(b_neg),
        .busy(busy), .done(done), .sum_val(sum_val), .sum_neg(sum_neg), .ovf(ovf)
    );

    typedef struct packed {
        logic        dec;
        logic        sub;
        logic        an;
        logic        bn;
        logic [1:0]  wc;
        logic [4:0]  lo;
        logic [4:0]  hi;
        logic [95:0] a;
        logic [95:0] b;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0, 5'd5,  96'h00_1234, 96'h00_0FFF},
        '{1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 5'd0, 5'd11, 96'h0_0000_4567_8912, 96'h0_0000_5432_1098},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 5'd0, 5'd5,  96'h00_0500, 96'h00_0123},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 5'd0, 5'd5,  96'h00_0123, 96'h00_0500},
        '{1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 5'd3, 5'd14, 96'hAB_CDEF_0123_4567_89AB, 96'h12_3456_789A_BCDE_F012},
        '{1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 5'd0, 5'd23, {24{4'h9}}, 96'h1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 5'd20, 5'd23, {24{4'hF}}, {24{4'h1}}},
        '{1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 5'd4, 5'd9, 96'h77_7777_7777, 96'h77_7777_7777}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // independent model: compare magnitudes, then add or subtract directly
    task automatic model(input logic dec, sub, an, bn, input logic [1:0] wc,
                         input logic [4:0] lo, hi, input logic [95:0] a, b,
                         output logic [95:0] r, output logic neg, output logic ov,
                         output logic swapped, output int nd);
        int top, lo_e, hi_e, base, c, s, x, y;
        bit esub, ge, found;
        top  = (int'(wc) + 1) * 6 - 1;
        hi_e = (int'(hi) < top) ? int'(hi) : top;
        lo_e = (int'(lo) > hi_e) ? hi_e : int'(lo);
        nd   = hi_e - lo_e + 1;
        base = dec ? 10 : 16;
        esub = sub ^ an ^ bn;
        r = a; ov = 0; swapped = 0; neg = an;
        if (!esub) begin
            c = 0;
            for (int i = lo_e; i <= hi_e; i++) begin
                s = int'(a[i*4 +: 4]) + int'(b[i*4 +: 4]) + c;
                c = (s >= base) ? 1 : 0;
                r[i*4 +: 4] = 4'(s - c * base);
            end
            ov = (c == 1);
        end else begin
            ge = 1; found = 0;
            for (int i = hi_e; i >= lo_e; i--) begin
                if (!found && a[i*4 +: 4] != b[i*4 +: 4]) begin
                    ge = a[i*4 +: 4] > b[i*4 +: 4];
                    found = 1;
                end
            end
            c = 0;
            for (int i = lo_e; i <= hi_e; i++) begin
                x = ge ? int'(a[i*4 +: 4]) : int'(b[i*4 +: 4]);
                y = ge ? int'(b[i*4 +: 4]) : int'(a[i*4 +: 4]);
                s = x - y - c;
                c = (s < 0) ? 1 : 0;
                r[i*4 +: 4] = 4'(s + c * base);
            end
            swapped = !ge;
            neg = ge ? an : ~an;
        end
    endtask

    task automatic run_case(input string tag, input logic dec, sub, an, bn,
                            input logic [1:0] wc, input logic [4:0] lo, hi,
                            input logic [95:0] a, b);
        logic [95:0] er; logic en, eo, sw; int nd, lat, exp_lat;
        string rq;
        model(dec, sub, an, bn, wc, lo, hi, a, b, er, en, eo, sw, nd);
        dec_mode = dec; sub_op = sub; a_neg = an; b_neg = bn;
        word_cnt = wc; fld_lo = lo; fld_hi = hi; a_val = a; b_val = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = sw ? 2 * nd + 1 : nd + 1;
        rq = (sub ^ an ^ bn) ? (sw ? "R5" : "R4") : (dec ? "R3" : "R2");
        chk(sum_val == er, {tag, "/", rq}, "result", sum_val, er);
        chk(sum_neg == en, {tag, "/R9"}, "sign", 96'(sum_neg), 96'(en));
        chk(ovf == eo, {tag, "/R8"}, "overflow", 96'(ovf), 96'(eo));
        chk(lat == exp_lat, {tag, "/R11"}, "latency", 96'(lat), 96'(exp_lat));
        @(negedge clk);
        chk(!done, {tag, "/R11"}, "done pulse", 96'(done), 96'(0));
    endtask

    function automatic logic [95:0] rand_opnd(input logic dec);
        logic [95:0] v;
        for (int i = 0; i < 24; i++)
            v[i*4 +: 4] = dec ? 4'($urandom % 10) : 4'($urandom % 16);
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 0; dec_mode = 0; sub_op = 0; a_neg = 0; b_neg = 0;
        word_cnt = 0; fld_lo = 0; fld_hi = 0; a_val = '0; b_val = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !ovf && !sum_neg, "R1", "flags",
            96'({busy, done, ovf, sum_neg}), 96'(0));
        chk(sum_val == '0, "R1", "result", sum_val, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && sum_val == '0, "R1", "idle after reset", sum_val, '0);

        for (int k = 0; k < NVEC; k++)
            run_case("TBL", VECS[k].dec, VECS[k].sub, VECS[k].an, VECS[k].bn,
                     VECS[k].wc, VECS[k].lo, VECS[k].hi, VECS[k].a, VECS[k].b);

        // R3: hand value 95 + 7 = 102 in decimal
        run_case("R3", 1, 0, 0, 0, 2'd0, 5'd0, 5'd5, 96'h95, 96'h07);
        chk(sum_val[23:0] == 24'h000102, "R3", "bcd 95+7", sum_val, 96'h102);

        // R8: 999999 + 1 wraps to zero with overflow
        run_case("R8", 1, 0, 0, 0, 2'd0, 5'd0, 5'd5, 96'h999999, 96'h1);
        chk(ovf == 1'b1 && sum_val[23:0] == 24'h0, "R8", "wrap overflow", sum_val, 96'h0);

        // R9: unlike signs with add become a subtraction: 50 + (-20) = 30
        run_case("R9", 1, 0, 0, 1, 2'd0, 5'd0, 5'd5, 96'h50, 96'h20);
        chk(sum_val[23:0] == 24'h30 && !sum_neg, "R9", "mixed add", sum_val, 96'h30);
        // R9: subtracting a negative adds: 50 - (-20) = 70
        run_case("R9", 1, 1, 0, 1, 2'd0, 5'd0, 5'd5, 96'h50, 96'h20);
        chk(sum_val[23:0] == 24'h70 && !sum_neg, "R9", "sub negative", sum_val, 96'h70);

        // R5: 3 - 8 = -5
        run_case("R5", 0, 1, 0, 0, 2'd0, 5'd0, 5'd5, 96'h3, 96'h8);
        chk(sum_val[23:0] == 24'h5 && sum_neg, "R5", "recomp", sum_val, 96'h5);

        // R7: field digits 2..3 of 9900 + 0100 -> 0000, digit 4 untouched
        run_case("R7", 1, 0, 0, 0, 2'd0, 5'd2, 5'd3, 96'h0_9900, 96'h1_0100);
        chk(sum_val[23:0] == 24'h00_0000, "R7", "no carry past field", sum_val, 96'h0);

        // R10: one word with field top 23 is clamped to digit 5
        run_case("R10", 0, 0, 0, 0, 2'd0, 5'd0, 5'd23,
                 {24{4'h5}}, {24{4'h1}});
        chk(sum_val[95:24] == {18{4'h5}} && sum_val[23:0] == {6{4'h6}},
            "R10", "clamp", sum_val, {{18{4'h5}}, {6{4'h6}}});

        // R6 + R11: start while busy is ignored
        dec_mode = 0; sub_op = 0; a_neg = 0; b_neg = 0; word_cnt = 2'd3;
        fld_lo = 5'd0; fld_hi = 5'd7; a_val = 96'h1111_1111; b_val = 96'h2222_2222;
        start = 1; @(negedge clk); start = 0;
        @(negedge clk); @(negedge clk);
        a_val = {24{4'hA}}; b_val = {24{4'hB}}; fld_hi = 5'd23; start = 1;
        @(negedge clk); start = 0;
        begin
            int w = 0;
            while (!done && w < 100) begin @(negedge clk); w++; end
        end
        chk(sum_val == 96'h3333_3333, "R11", "start ignored while busy", sum_val, 96'h3333_3333);
        repeat (30) @(negedge clk);
        chk(!busy && sum_val == 96'h3333_3333, "R6", "no second run", sum_val, 96'h3333_3333);

        // random sweep over modes, lengths and field bounds
        for (int k = 0; k < 80; k++) begin
            logic d; logic [1:0] wc; int top, lo, hi;
            d = 1'($urandom % 2);
            wc = 2'($urandom % 4);
            top = (int'(wc) + 1) * 6 - 1;
            lo = $urandom % (top + 1);
            hi = lo + ($urandom % (top - lo + 1));
            run_case("RND", d, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                     wc, 5'(lo), 5'(hi), rand_opnd(d), rand_opnd(d));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule